// File: doc/BRIEF.md
# Dual-Lane Serial Frame Receiver

This block turns a serial bit stream back into frames. It runs on the clock that arrives with the data. Each data line is sampled on both clock edges, and the design models this as a two-bit sample per line per clock. Bit [1] is the sample from the first edge, so it is the earlier bit.

While idle the receiver watches lane 0 for a start marker. Once it finds one, it collects the header, the payload, the check byte, the tag and the trailer. It then reports the frame as good, as corrupted, or as badly framed.

The frame has two kinds of field:
- **Overhead fields** (start marker, type, tag and trailer) always travel on lane 0 at two bits per clock.
- **Payload fields** (user byte, data words and check byte) use both lanes at four bits per clock when dual-lane mode is selected.

The receiver therefore changes its sample width partway through each frame. The number of data words is a build parameter. The captured user byte, words and tag stay on the outputs until the next frame overwrites them. The three status outputs are one-cycle pulses.

Top module: `dlane_frame_rx`

## Requirements
- R1: After reset, `user_byte`, `word_buf` and `frame_tag` are zero, no status pulse is raised, and the receiver is hunting for a frame start.
- R2: A frame starts only when eight consecutive lane-0 bits read 1111 followed by 1001. Bits are taken two per clock, with `lane0_s[1]` first. No other 8-bit window starts a frame.
- R3: After the start marker the fields arrive in this order, each MSB first: a 4-bit type, an 8-bit user byte, N_WORDS 16-bit words (word 0 first, placed in `word_buf[15:0]`), an 8-bit check byte, a 4-bit tag, a 4-bit end code and a 4-bit trailer.
- R4: In dual-lane mode, the user byte, the words and the check byte arrive at 4 bits per clock, in the order `lane0_s[1]`, `lane1_s[1]`, `lane0_s[0]`, `lane1_s[0]`. Every other field arrives at 2 bits per clock on lane 0 alone, and lane 1 is ignored for those fields.
- R5: In single-lane mode every field arrives at 2 bits per clock on lane 0, and lane 1 is ignored throughout.
- R6: The lane mode is taken from `dual_lane` in the clock where the start marker completes. It holds for that whole frame, whatever `dual_lane` does afterwards.
- R7: The check byte is compared with a CRC-8 computed over the user byte and the words, MSB first. The CRC uses polynomial 0x07 and initial value 0x00. A mismatch raises `crc_err` for one cycle when the frame ends.
- R8: A type code other than 0011 raises `frame_err` for one cycle, in the clock after the type field is sampled. The receiver then hunts again.
- R9: An end code other than 0110 raises `frame_err` in the clock after the end code, and the receiver hunts again. A trailer other than 1111 raises `frame_err` in the clock after the trailer.
- R10: `frame_valid` pulses for exactly one cycle, in the clock after the last trailer bits, and only when the CRC, the end code and the trailer all check. It never coincides with `crc_err` or `frame_err`. The captured fields hold afterwards.
- R11: A frame whose start marker follows the previous trailer directly, with no idle bits between them, is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_lane | input | 1 | 1 selects two-lane payload transfer |
| lane0_s | input | 2 | Lane 0 samples for this clock; bit 1 is earlier |
| lane1_s | input | 2 | Lane 1 samples for this clock; bit 1 is earlier |
| user_byte | output | 8 | Last captured user byte |
| word_buf | output | N_WORDS*16 | Last captured words; word i is at bits [16*i+15:16*i] |
| frame_tag | output | 4 | Last captured tag |
| frame_valid | output | 1 | One-cycle pulse for a frame that passed every check |
| crc_err | output | 1 | One-cycle pulse when the check byte mismatched |
| frame_err | output | 1 | One-cycle pulse on a bad type, end code or trailer |

## Verification
The assertions check on every cycle that:
- a detected start marker always leads into the type field;
- a bad type or bad end code is always followed by a framing pulse and a return to hunting;
- a good-frame pulse lasts one cycle, comes straight out of the trailer field and never overlaps an error pulse;
- the CRC register is cleared at each frame start.

Only the bench scenarios can show that:
- fields land in the right output bits under both lane mappings;
- the good-frame pulse arrives in the exact clock that the per-field rates predict;
- a mode change in the middle of a frame, a near-miss start pattern and back-to-back frames leave reception intact.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT, ST_TYPE, ST_USER, ST_WORD, ST_CRC, ST_TAG, ST_EOF, ST_POST
  } rx_state_e;

  localparam logic [7:0] START_PATTERN = 8'hF9;
  localparam logic [3:0] DATA_TYPE     = 4'h3;
  localparam logic [3:0] END_CODE      = 4'h6;
  localparam logic [3:0] TRAIL_CODE    = 4'hF;
  localparam logic [7:0] CRC_POLY      = 8'h07;

  // Fields carried on both lanes when dual-lane mode is active
  function automatic logic is_payload(input rx_state_e st);
    return (st == ST_USER) || (st == ST_WORD) || (st == ST_CRC);
  endfunction

  // Bits in one unit of the current field (a word counts as one unit)
  function automatic logic [4:0] field_len(input rx_state_e st);
    case (st)
      ST_USER, ST_CRC: return 5'd8;
      ST_WORD:         return 5'd16;
      default:         return 5'd4;
    endcase
  endfunction

  // Feed two or four MSB-first bits (left-aligned in bits) into a CRC-8
  function automatic logic [7:0] crc8_feed(input logic [7:0] crc_in,
                                           input logic [3:0] bits,
                                           input logic wide);
    logic [7:0] c;
    logic fb;
    c = crc_in;
    for (int i = 0; i < 4; i++) begin
      if (wide || i < 2) begin
        fb = c[7] ^ bits[3-i];
        c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/dlrx_lane_unpack.sv
module dlrx_lane_unpack (
  input  logic       wide,
  input  logic [1:0] lane0_s,
  input  logic [1:0] lane1_s,
  output logic [3:0] bits,
  output logic [2:0] step
);
  // Wide: even positions on lane 0, odd on lane 1, first edge first
  always_comb begin
    if (wide) begin
      bits = {lane0_s[1], lane1_s[1], lane0_s[0], lane1_s[0]};
      step = 3'd4;
    end else begin
      bits = {lane0_s[1], lane0_s[0], 2'b00};
      step = 3'd2;
    end
  end
endmodule

// File: rtl/dlrx_start_hunt.sv
module dlrx_start_hunt
  import dlrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] lane0_s,
  output logic       hit
);
  logic [7:0] win;
  logic [7:0] win_nx;

  assign win_nx = {win[5:0], lane0_s};
  assign hit    = en && (win_nx == START_PATTERN);

  // Window empties whenever a frame is in progress
  always_ff @(posedge clk) begin
    if (!rst_n || !en) win <= 8'h00;
    else               win <= win_nx;
  end
endmodule

// File: rtl/dlrx_crc_acc.sv
module dlrx_crc_acc
  import dlrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [3:0] bits,
  input  logic       wide,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= 8'h00;
    else if (en)       crc <= crc8_feed(crc, bits, wide);
  end

  // R7: the running CRC starts every frame from zero
  assert_crc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00));
endmodule

// File: rtl/dlane_frame_rx.sv
module dlane_frame_rx
  import dlrx_pkg::*;
#(
  parameter int N_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dual_lane,
  input  logic [1:0]           lane0_s,
  input  logic [1:0]           lane1_s,
  output logic [7:0]           user_byte,
  output logic [N_WORDS*16-1:0] word_buf,
  output logic [3:0]           frame_tag,
  output logic                 frame_valid,
  output logic                 crc_err,
  output logic                 frame_err
);
  localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(N_WORDS - 1);

  rx_state_e         st;
  logic              mode_q;
  logic [13:0]       acc;
  logic [15:0]       acc_nx;
  logic [4:0]        bitcnt;
  logic [4:0]        cnt_nx;
  logic [WIDX_W-1:0] widx;
  logic              crc_bad_q;
  logic [15:0]       words_q [N_WORDS];

  logic       wide;
  logic [3:0] in_bits;
  logic [2:0] step;
  logic       sof_hit;
  logic [7:0] crc_val;

  // Named events for the checks
  logic unit_done;
  logic type_bad_ev;
  logic eof_bad_ev;
  logic post_end_ev;
  logic crc_mismatch;

  assign wide = mode_q && is_payload(st);

  dlrx_lane_unpack u_unpack (
    .wide    (wide),
    .lane0_s (lane0_s),
    .lane1_s (lane1_s),
    .bits    (in_bits),
    .step    (step)
  );

  dlrx_start_hunt u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st == ST_HUNT),
    .lane0_s (lane0_s),
    .hit     (sof_hit)
  );

  dlrx_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sof_hit),
    .en    ((st == ST_USER) || (st == ST_WORD)),
    .bits  (in_bits),
    .wide  (wide),
    .crc   (crc_val)
  );

  always_comb begin
    if (step == 3'd4) acc_nx = {acc[11:0], in_bits};
    else              acc_nx = {acc[13:0], in_bits[3:2]};
  end

  assign cnt_nx       = bitcnt + 5'(step);
  assign unit_done    = (st != ST_HUNT) && (cnt_nx == field_len(st));
  assign type_bad_ev  = unit_done && (st == ST_TYPE) && (acc_nx[3:0] != DATA_TYPE);
  assign eof_bad_ev   = unit_done && (st == ST_EOF)  && (acc_nx[3:0] != END_CODE);
  assign post_end_ev  = unit_done && (st == ST_POST);
  assign crc_mismatch = acc_nx[7:0] != crc_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_HUNT;
      mode_q      <= 1'b0;
      acc         <= '0;
      bitcnt      <= '0;
      widx        <= '0;
      crc_bad_q   <= 1'b0;
      user_byte   <= '0;
      frame_tag   <= '0;
      frame_valid <= 1'b0;
      crc_err     <= 1'b0;
      frame_err   <= 1'b0;
      for (int i = 0; i < N_WORDS; i++) words_q[i] <= '0;
    end else begin
      frame_valid <= 1'b0;
      crc_err     <= 1'b0;
      frame_err   <= 1'b0;
      if (st == ST_HUNT) begin
        if (sof_hit) begin
          st        <= ST_TYPE;
          mode_q    <= dual_lane;
          acc       <= '0;
          bitcnt    <= '0;
          widx      <= '0;
          crc_bad_q <= 1'b0;
        end
      end else begin
        acc    <= acc_nx[13:0];
        bitcnt <= unit_done ? 5'd0 : cnt_nx;
        if (unit_done) begin
          case (st)
            ST_TYPE: begin
              if (type_bad_ev) begin
                st        <= ST_HUNT;
                frame_err <= 1'b1;
              end else begin
                st <= ST_USER;
              end
            end
            ST_USER: begin
              user_byte <= acc_nx[7:0];
              st        <= ST_WORD;
            end
            ST_WORD: begin
              words_q[widx] <= acc_nx;
              if (widx == LAST_WORD) st <= ST_CRC;
              else                   widx <= widx + 1'b1;
            end
            ST_CRC: begin
              crc_bad_q <= crc_mismatch;
              st        <= ST_TAG;
            end
            ST_TAG: begin
              frame_tag <= acc_nx[3:0];
              st        <= ST_EOF;
            end
            ST_EOF: begin
              if (eof_bad_ev) begin
                st        <= ST_HUNT;
                frame_err <= 1'b1;
                crc_err   <= crc_bad_q;
              end else begin
                st <= ST_POST;
              end
            end
            default: begin
              st          <= ST_HUNT;
              frame_err   <= (acc_nx[3:0] != TRAIL_CODE);
              crc_err     <= crc_bad_q;
              frame_valid <= (acc_nx[3:0] == TRAIL_CODE) && !crc_bad_q;
            end
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_out
    assign word_buf[16*g +: 16] = words_q[g];
  end

  assert_sof_to_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_hit |=> (st == ST_TYPE));

  assert_bad_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    type_bad_ev |=> (frame_err && st == ST_HUNT && !frame_valid));

  assert_bad_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eof_bad_ev |=> (frame_err && st == ST_HUNT));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_valid_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (!crc_err && !frame_err));

  assert_valid_after_post_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ($past(st) == ST_POST && st == ST_HUNT));

  assert_post_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    post_end_ev |=> (st == ST_HUNT));
endmodule

// File: tb/dlane_frame_rx_test.sv
module dlane_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_lane = 1'b0;
  logic [1:0] lane0_s = 2'b11;
  logic [1:0] lane1_s = 2'b11;
  logic [7:0] user_byte;
  logic [NW*16-1:0] word_buf;
  logic [3:0] frame_tag;
  logic frame_valid, crc_err, frame_err;

  dlane_frame_rx #(.N_WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .dual_lane(dual_lane),
    .lane0_s(lane0_s), .lane1_s(lane1_s),
    .user_byte(user_byte), .word_buf(word_buf), .frame_tag(frame_tag),
    .frame_valid(frame_valid), .crc_err(crc_err), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic tb_bits [0:2047];
  logic tb_eff  [0:2047];
  int   tb_len;
  logic [15:0] tx_words [NW];

  int n_valid, n_ferr, n_cerr, t_valid, t_ferr, t_cerr;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v, input int n, input logic eff);
    for (int i = n - 1; i >= 0; i--) begin
      tb_bits[tb_len] = v[i];
      tb_eff[tb_len]  = eff;
      tb_len++;
    end
  endtask

  // Byte-serial CRC-8, poly 0x07, init 0
  function automatic logic [7:0] ref_crc(input logic [7:0] user);
    logic [7:0] c;
    logic [7:0] byt;
    c = 8'h00;
    for (int k = 0; k < 1 + 2*NW; k++) begin
      if (k == 0)          byt = user;
      else if (k % 2 == 1) byt = tx_words[(k-1)/2][15:8];
      else                 byt = tx_words[(k-1)/2][7:0];
      for (int b = 7; b >= 0; b--) begin
        if (c[7] ^ byt[b]) c = {c[6:0], 1'b0} ^ 8'h07;
        else               c = {c[6:0], 1'b0};
      end
    end
    return c;
  endfunction

  task automatic build(input logic [3:0] ft, input logic [7:0] user,
                       input logic [7:0] crc_x, input logic [3:0] tg,
                       input logic [3:0] eofc, input logic [3:0] postc,
                       input bit stop_after_type);
    push(16'hF, 4, 1'b0);
    push(16'h9, 4, 1'b0);
    push({12'h0, ft}, 4, 1'b0);
    if (!stop_after_type) begin
      push({8'h0, user}, 8, 1'b1);
      for (int w = 0; w < NW; w++) push(tx_words[w], 16, 1'b1);
      push({8'h0, ref_crc(user) ^ crc_x}, 8, 1'b1);
      push({12'h0, tg}, 4, 1'b0);
      push({12'h0, eofc}, 4, 1'b0);
      push({12'h0, postc}, 4, 1'b0);
    end
  endtask

  task automatic record(input int tag);
    if (frame_valid) begin n_valid++; t_valid = tag; end
    if (frame_err)   begin n_ferr++;  t_ferr  = tag; end
    if (crc_err)     begin n_cerr++;  t_cerr  = tag; end
  endtask

  // Drive the buffer; group g is applied at negedge g, its result seen at tag g+1
  task automatic drive(input logic fmt_dual, input int flip_at);
    int p;
    int g;
    p = 0; g = 0;
    n_valid = 0; n_ferr = 0; n_cerr = 0;
    t_valid = -1; t_ferr = -1; t_cerr = -1;
    while (p < tb_len) begin
      @(negedge clk);
      record(g);
      if (g == flip_at) dual_lane = ~dual_lane;
      if (tb_eff[p] && fmt_dual) begin
        lane0_s = {tb_bits[p],   tb_bits[p+2]};
        lane1_s = {tb_bits[p+1], tb_bits[p+3]};
        p += 4;
      end else begin
        lane0_s = {tb_bits[p], tb_bits[p+1]};
        lane1_s = {~tb_bits[p+1], tb_bits[p]};
        p += 2;
      end
      g++;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      record(g + k);
      lane0_s = 2'b11;
      lane1_s = 2'b11;
    end
    tb_len = 0;
  endtask

  task automatic set_words(input logic [15:0] seed);
    for (int w = 0; w < NW; w++) tx_words[w] = seed ^ (16'h1357 * 16'(w + 1));
  endtask

  task automatic check_good(input string req, input logic [7:0] user,
                            input logic [3:0] tg, input int exp_tag);
    logic [NW*16-1:0] exp_buf;
    for (int w = 0; w < NW; w++) exp_buf[16*w +: 16] = tx_words[w];
    chk(req, "valid count", 128'(n_valid), 128'd1);
    chk(req, "valid timing", 128'(t_valid), 128'(exp_tag));
    chk(req, "no frame_err", 128'(n_ferr), 128'd0);
    chk(req, "no crc_err", 128'(n_cerr), 128'd0);
    chk(req, "user byte", 128'(user_byte), 128'(user));
    chk(req, "tag", 128'(frame_tag), 128'(tg));
    chk(req, "words", 128'(word_buf), 128'(exp_buf));
  endtask

  task automatic t_reset;
    chk("R1", "user after reset", 128'(user_byte), 128'd0);
    chk("R1", "words after reset", 128'(word_buf), 128'd0);
    chk("R1", "tag after reset", 128'(frame_tag), 128'd0);
    chk("R1", "flags after reset", 128'({frame_valid, crc_err, frame_err}), 128'd0);
  endtask

  task automatic t_dual_good;
    dual_lane = 1'b1;
    set_words(16'hA1B2);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'hA5, 8'h00, 4'hC, 4'h6, 4'hF, 1'b0);
    drive(1'b1, -1);
    check_good("R4", 8'hA5, 4'hC, 50);
    chk("R3", "word 0 low bits", 128'(word_buf[15:0]), 128'(tx_words[0]));
  endtask

  task automatic t_single_good;
    dual_lane = 1'b0;
    set_words(16'h0F3C);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'h3E, 8'h00, 4'h5, 4'h6, 4'hF, 1'b0);
    drive(1'b0, -1);
    check_good("R5", 8'h3E, 4'h5, 86);
  endtask

  task automatic t_crc_bad;
    dual_lane = 1'b1;
    set_words(16'h7777);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'h11, 8'h5A, 4'h2, 4'h6, 4'hF, 1'b0);
    drive(1'b1, -1);
    chk("R7", "crc_err count", 128'(n_cerr), 128'd1);
    chk("R7", "crc_err timing", 128'(t_cerr), 128'd50);
    chk("R7", "no valid on bad crc", 128'(n_valid), 128'd0);
    chk("R7", "no frame_err on bad crc", 128'(n_ferr), 128'd0);
  endtask

  task automatic t_bad_type;
    dual_lane = 1'b1;
    push(16'hF, 4, 1'b0);
    build(4'h5, 8'h00, 8'h00, 4'h0, 4'h6, 4'hF, 1'b1);
    drive(1'b1, -1);
    chk("R8", "frame_err count", 128'(n_ferr), 128'd1);
    chk("R8", "frame_err timing", 128'(t_ferr), 128'd8);
    chk("R8", "no valid", 128'(n_valid), 128'd0);
    chk("R8", "no crc_err", 128'(n_cerr), 128'd0);
    set_words(16'h4242);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'h99, 8'h00, 4'h9, 4'h6, 4'hF, 1'b0);
    drive(1'b1, -1);
    check_good("R8", 8'h99, 4'h9, 50);
  endtask

  task automatic t_bad_trailer;
    dual_lane = 1'b1;
    set_words(16'h2468);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'h12, 8'h00, 4'h3, 4'h2, 4'hF, 1'b0);
    drive(1'b1, -1);
    chk("R9", "bad end code frame_err", 128'(n_ferr), 128'd1);
    chk("R9", "bad end code timing", 128'(t_ferr), 128'd48);
    chk("R9", "bad end code no valid", 128'(n_valid), 128'd0);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'h34, 8'h00, 4'h3, 4'h6, 4'h7, 1'b0);
    drive(1'b1, -1);
    chk("R9", "bad trailer frame_err", 128'(n_ferr), 128'd1);
    chk("R9", "bad trailer timing", 128'(t_ferr), 128'd50);
    chk("R9", "bad trailer no valid", 128'(n_valid), 128'd0);
  endtask

  task automatic t_mode_flip;
    dual_lane = 1'b1;
    set_words(16'hBEEF);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'hC3, 8'h00, 4'hA, 4'h6, 4'hF, 1'b0);
    drive(1'b1, 10);
    check_good("R6", 8'hC3, 4'hA, 50);
  endtask

  task automatic t_back_to_back;
    dual_lane = 1'b1;
    set_words(16'h1111);
    push(16'hF, 4, 1'b0);
    build(4'h3, 8'h01, 8'h00, 4'h1, 4'h6, 4'hF, 1'b0);
    set_words(16'h5AA5);
    build(4'h3, 8'h02, 8'h00, 4'h7, 4'h6, 4'hF, 1'b0);
    drive(1'b1, -1);
    chk("R11", "two valid pulses", 128'(n_valid), 128'd2);
    chk("R11", "second valid timing", 128'(t_valid), 128'd98);
    chk("R11", "second user byte", 128'(user_byte), 128'h02);
    chk("R11", "second tag", 128'(frame_tag), 128'h7);
    chk("R11", "second word 7", 128'(word_buf[16*(NW-1) +: 16]), 128'(tx_words[NW-1]));
  endtask

  task automatic t_false_start;
    dual_lane = 1'b1;
    set_words(16'hC0DE);
    push(16'hF, 4, 1'b0);
    push(16'hF, 4, 1'b0);
    push(16'hB, 4, 1'b0);
    build(4'h3, 8'h6B, 8'h00, 4'hE, 4'h6, 4'hF, 1'b0);
    drive(1'b1, -1);
    check_good("R2", 8'h6B, 4'hE, 54);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tb_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dual_good();
    t_single_good();
    t_crc_bad();
    t_bad_type();
    t_bad_trailer();
    t_mode_flip();
    t_back_to_back();
    t_false_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule